// File: doc/BRIEF.md
# Two-Share Masked Bit-Serial Feistel Block Cipher Core

This core encrypts one 128-bit block under a 128-bit key with the lightweight AND-rotate-XOR Feistel cipher in its 128/128 variant. That variant runs 68 rounds over two 64-bit words. Every value inside the core is held as two Boolean shares, so no register ever holds a plain plaintext, key or state bit. The caller splits the plaintext and the key into two shares outside the core. It shifts those shares in one bit per clock and receives the ciphertext as two shares, one bit per clock. The caller XORs the two output shares to recover the ciphertext. The core never recombines them.

A round maps (x, y) to (y ^ f(x) ^ k, x), where f(x) = (rotl1(x) & rotl8(x)) ^ rotl2(x). The core computes one new x bit per clock, so a round takes 64 clocks. Three rotation taps come from a pair of 8-bit history registers per share. One register supplies the taps while the other records the freshly computed bits, and the two swap roles at every round boundary. All linear work (XOR, taps, key addition and the key recurrence) is done separately in each share. The round-constant injection is applied to share 0 only. The single non-linear AND is a two-share gadget. It takes one fresh random bit per clock from a small free-running LFSR.

Top module: `mfc_top`

## Requirements
- R1: After reset `busy`, `outValid` and `done` are 0.
- R2: A `start` seen high while idle begins a load of exactly 128 clocks. On load clock n (0..127), `ptShareIn[s]` and `keyShareIn[s]` carry bit n of share s of the 128-bit plaintext and of the key. Bits 0..63 are the y word and key word k0; bits 64..127 are the x word and key word k1. Each word goes in LSB first.
- R3: After the last load bit, the rounds take exactly ROUNDS*64 clocks (4352 by default). `outValid` is first seen high 4352 clocks after the last load clock.
- R4: The XOR of the two output shares equals the 128/128 cipher output. For the key 0f0e0d0c0b0a0908_0706050403020100 and plaintext 6373656420737265_6c6c657661727420, the output is 49681b1e1e54fe3f_65aa832af84e0bbc (x word high).
- R5: With both masks zero (share 1 all zero), the recombined output is the same ciphertext.
- R6: For any split of the same plaintext and key, the recombined output is the same ciphertext.
- R7: The output lasts exactly 128 clocks with `outValid` high. It carries bit m of the ciphertext shares on clock m: the y word first, then the x word, each LSB first. `done` is high only on the last of these clocks. In the next clock `busy` and `outValid` are 0.
- R8: `start` is ignored while `busy` is high: neither the latency nor the result changes.
- R9: At the first bit of every round, the active tap register holds the current x bits 63 down to 56. The two 8-bit registers exchange the tap and capture roles at each round boundary.
- R10: The random source never reaches the all-zero state. The recombined output does not depend on the random bits it supplies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a load when idle |
| ptShareIn | input | 2 | Serial plaintext bit, one per share |
| keyShareIn | input | 2 | Serial key bit, one per share |
| busy | output | 1 | High from load until output finishes |
| ctShareOut | output | 2 | Serial ciphertext bit, one per share |
| outValid | output | 1 | High during the 128 output clocks |
| done | output | 1 | Marks the last output clock |

## Verification
The hardest condition to reach is a round boundary. There, the tap register being read must already hold bits that were written into the other register one round earlier. Any slip in the role swap or the tap order shows up only after many rounds, as a wrong ciphertext. The stimulus therefore runs complete encryptions: the known-answer vector with zero masks, all-ones masks and random splits, plus random plaintext and key pairs. The bench recombines the shares and compares them against a word-level reference function. A stray `start` is injected in the middle of one run, and the LFSR state differs between runs, so correctness is also shown for varying random bits.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int WORD_W = 64;
  localparam int SR_W   = 8;
  localparam int Z_LEN  = 62;
  localparam int XFER_W = $clog2(2 * WORD_W);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int Z_W    = $clog2(Z_LEN);
  // constant sequence of the 128/128 variant, element 0 in the MSB
  localparam logic [Z_LEN-1:0] ZSEQ =
    62'b10101111011100000011010010011000101000010001111110010110110011;

  typedef struct packed {
    logic load;
    logic run;
    logic unload;
    logic parity;
    logic firstBit;
    logic lastBit;
    logic kConst;
  } mfcStrobe_t;
endpackage

// File: rtl/mfc_lfsr.sv
module mfc_lfsr #(
  parameter int W = 3,
  parameter logic [W-1:0] TAPS = 3'b110,
  parameter logic [W-1:0] SEED = 3'b001
) (
  input  logic clk,
  input  logic rstN,
  output logic randBit
);
  logic [W-1:0] state;
  logic fb;

  assign fb = ^(state & TAPS);
  assign randBit = state[W-1];

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEED;
    else       state <= {state[W-2:0], fb};
  end

  // R10
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);
endmodule

// File: rtl/mfc_ctrl.sv
module mfc_ctrl
  import mfc_pkg::*;
#(
  parameter int ROUNDS = 68
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mfcStrobe_t strobe,
  output logic       busy,
  output logic       outValid,
  output logic       done
);
  localparam int RND_W = $clog2(ROUNDS);
  localparam logic [XFER_W-1:0] XFER_LAST  = XFER_W'(2 * WORD_W - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST   = BIT_W'(WORD_W - 1);
  localparam logic [RND_W-1:0]  ROUND_LAST = RND_W'(ROUNDS - 1);
  localparam logic [Z_W-1:0]    Z_LAST     = Z_W'(Z_LEN - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_UNLOAD} state_t;

  state_t            state;
  logic [XFER_W-1:0] xferCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [RND_W-1:0]  roundCnt;
  logic [Z_W-1:0]    zIdx;
  logic              zBit;
  logic              lastRunCycle;

  assign zBit = ZSEQ[Z_LAST - zIdx];
  assign lastRunCycle = (bitCnt == BIT_LAST) && (roundCnt == ROUND_LAST);

  always_comb begin
    strobe          = '0;
    strobe.load     = (state == ST_LOAD);
    strobe.run      = (state == ST_RUN);
    strobe.unload   = (state == ST_UNLOAD);
    strobe.parity   = roundCnt[0];
    strobe.firstBit = strobe.run && (bitCnt == '0);
    strobe.lastBit  = strobe.run && (bitCnt == BIT_LAST);
    strobe.kConst   = (bitCnt >= BIT_W'(2)) || ((bitCnt == '0) && zBit);
  end

  assign busy     = (state != ST_IDLE);
  assign outValid = (state == ST_UNLOAD);
  assign done     = outValid && (xferCnt == XFER_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      xferCnt  <= '0;
      bitCnt   <= '0;
      roundCnt <= '0;
      zIdx     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_LOAD;
            xferCnt <= '0;
          end
        end
        ST_LOAD: begin
          xferCnt <= xferCnt + 1'b1;
          if (xferCnt == XFER_LAST) begin
            state    <= ST_RUN;
            bitCnt   <= '0;
            roundCnt <= '0;
            zIdx     <= '0;
          end
        end
        ST_RUN: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == BIT_LAST) begin
            zIdx <= (zIdx == Z_LAST) ? '0 : zIdx + 1'b1;
            if (roundCnt == ROUND_LAST) begin
              state   <= ST_UNLOAD;
              xferCnt <= '0;
            end else begin
              roundCnt <= roundCnt + 1'b1;
            end
          end
        end
        default: begin
          xferCnt <= xferCnt + 1'b1;
          if (xferCnt == XFER_LAST) state <= ST_IDLE;
        end
      endcase
    end
  end

  // R2
  load_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && xferCnt != XFER_LAST) |=> state == ST_LOAD);
  // R3
  round_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> roundCnt <= ROUND_LAST);
  // R8
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && state == ST_RUN && !lastRunCycle) |=> state == ST_RUN);
  // R7
  unload_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !done) |=> outValid);
  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!outValid && !busy));
endmodule

// File: rtl/mfc_datapath.sv
module mfc_datapath
  import mfc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  mfcStrobe_t strobe,
  input  logic       randBit,
  input  logic [1:0] ptShareIn,
  input  logic [1:0] keyShareIn,
  output logic [1:0] ctShareOut
);
  // per-share taps: rotl1 -> tapA, rotl2 -> tapB, rotl8 -> tapC
  logic [1:0] tapA, tapB, tapC;
  logic [1:0] andOut;
  logic       zCross;

  // two-share AND gadget; linear parts stay inside each share
  assign andOut[0] = (tapA[0] & tapC[0]) ^ randBit;
  assign zCross    = (randBit ^ (tapA[0] & tapC[1])) ^ (tapA[1] & tapC[0]);
  assign andOut[1] = (tapA[1] & tapC[1]) ^ zCross;

  for (genvar s = 0; s < 2; s++) begin : g_share
    logic [WORD_W-1:0] xReg, yReg, kCur, kNext;
    logic [SR_W-1:0]   srDown, srUp, tapReg;
    logic              newBit, newKey, constBit;

    assign tapReg  = strobe.parity ? srUp : srDown;
    assign tapA[s] = tapReg[0];
    assign tapB[s] = tapReg[1];
    assign tapC[s] = tapReg[SR_W-1];
    assign constBit = (s == 0) ? strobe.kConst : 1'b0;
    assign newBit  = yReg[0] ^ andOut[s] ^ tapB[s] ^ kCur[0];
    assign newKey  = kCur[0] ^ kNext[3] ^ kNext[4] ^ constBit;
    assign ctShareOut[s] = yReg[0];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        xReg   <= '0;
        yReg   <= '0;
        kCur   <= '0;
        kNext  <= '0;
        srDown <= '0;
        srUp   <= '0;
      end else if (strobe.load) begin
        xReg   <= {ptShareIn[s], xReg[WORD_W-1:1]};
        yReg   <= {xReg[0], yReg[WORD_W-1:1]};
        kNext  <= {keyShareIn[s], kNext[WORD_W-1:1]};
        kCur   <= {kNext[0], kCur[WORD_W-1:1]};
        srDown <= {srDown[SR_W-2:0], ptShareIn[s]};
      end else if (strobe.run) begin
        xReg <= {newBit, xReg[WORD_W-1:1]};
        yReg <= {xReg[0], yReg[WORD_W-1:1]};
        if (!strobe.parity) begin
          srDown <= {srDown[SR_W-2:0], xReg[0]};
          srUp   <= {srUp[SR_W-2:0], newBit};
        end else begin
          srUp   <= {srUp[SR_W-2:0], xReg[0]};
          srDown <= {srDown[SR_W-2:0], newBit};
        end
        if (strobe.lastBit) begin
          kCur  <= {kNext[0], kNext[WORD_W-1:1]};
          kNext <= {newKey, kCur[WORD_W-1:1]};
        end else begin
          kCur  <= {newKey, kCur[WORD_W-1:1]};
          kNext <= {kNext[0], kNext[WORD_W-1:1]};
        end
      end else if (strobe.unload) begin
        yReg <= {xReg[0], yReg[WORD_W-1:1]};
        xReg <= {1'b0, xReg[WORD_W-1:1]};
      end
    end

    // R9
    tap_align_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.firstBit |-> (tapReg[0] == xReg[WORD_W-1] &&
                           tapReg[SR_W-1] == xReg[WORD_W-SR_W]));
  end
endmodule

// File: rtl/mfc_top.sv
module mfc_top #(
  parameter int ROUNDS = 68,
  parameter int LFSR_W = 3,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 3'b110,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 3'b101
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] ptShareIn,
  input  logic [1:0] keyShareIn,
  output logic       busy,
  output logic [1:0] ctShareOut,
  output logic       outValid,
  output logic       done
);
  mfc_pkg::mfcStrobe_t strobe;
  logic randBit;

  mfc_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strobe(strobe),
    .busy(busy), .outValid(outValid), .done(done)
  );

  mfc_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rstN(rstN), .randBit(randBit)
  );

  mfc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .randBit(randBit),
    .ptShareIn(ptShareIn), .keyShareIn(keyShareIn), .ctShareOut(ctShareOut)
  );
endmodule

// File: tb/tb_mfc_top.sv
module tb_mfc_top;
  localparam logic [127:0] KAT_PT  = 128'h63736564207372656c6c657661727420;
  localparam logic [127:0] KAT_KEY = 128'h0f0e0d0c0b0a09080706050403020100;
  localparam logic [127:0] KAT_CT  = 128'h49681b1e1e54fe3f65aa832af84e0bbc;
  localparam logic [61:0]  ZREF =
    62'b10101111011100000011010010011000101000010001111110010110110011;
  localparam int RUN_CYC = 68 * 64;

  logic clk = 0, rstN = 0, start = 0;
  logic [1:0] ptShareIn = 0, keyShareIn = 0, ctShareOut;
  logic busy, outValid, done;
  int testCnt = 0, failCnt = 0;

  always #5 clk = ~clk;

  mfc_top dut (
    .clk(clk), .rstN(rstN), .start(start), .ptShareIn(ptShareIn),
    .keyShareIn(keyShareIn), .busy(busy), .ctShareOut(ctShareOut),
    .outValid(outValid), .done(done)
  );

  function automatic logic [63:0] rol(input logic [63:0] v, input int n);
    return (v << n) | (v >> (64 - n));
  endfunction

  function automatic logic [127:0] cipherRef(input logic [127:0] pt, input logic [127:0] key);
    logic [63:0] x, y, k0, k1, t, nk;
    x = pt[127:64]; y = pt[63:0]; k0 = key[63:0]; k1 = key[127:64];
    for (int i = 0; i < 68; i++) begin
      t = x;
      x = y ^ (rol(x, 1) & rol(x, 8)) ^ rol(x, 2) ^ k0;
      y = t;
      nk = ~64'd3 ^ {63'd0, ZREF[61 - (i % 62)]} ^ k0 ^ rol(k1, 61) ^ rol(k1, 60);
      k0 = k1; k1 = nk;
    end
    return {x, y};
  endfunction

  task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic encrypt(input logic [127:0] pt, input logic [127:0] key,
                         input logic [127:0] mp, input logic [127:0] mk,
                         input int injectAt, input string tag);
    logic [127:0] s0p, s0k, res, expct;
    int lat;
    logic doneOk;
    s0p = pt ^ mp; s0k = key ^ mk;
    expct = cipherRef(pt, key);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int n = 0; n < 128; n++) begin
      ptShareIn  = {mp[n], s0p[n]};
      keyShareIn = {mk[n], s0k[n]};
      @(negedge clk);
    end
    ptShareIn = 0; keyShareIn = 0;
    lat = 0;
    while (!outValid && lat < 10000) begin
      start = (lat == injectAt);
      @(negedge clk);
      lat++;
    end
    start = 0;
    // R3: latency of the rounds
    check(lat == RUN_CYC, {tag, " R3 latency"}, 128'(lat), 128'(RUN_CYC));
    res = '0; doneOk = 1;
    for (int m = 0; m < 128; m++) begin
      res[m] = ctShareOut[0] ^ ctShareOut[1];
      if (done != (m == 127) || !outValid) doneOk = 0;
      @(negedge clk);
    end
    // R7: output framing
    check(doneOk && !busy && !outValid, {tag, " R7 framing"},
          {125'd0, doneOk, busy, outValid}, 128'h4);
    // R2 R4 R6 R9 R10: recombined ciphertext
    check(res == expct, {tag, " R2 R4 R6 R9 R10 ciphertext"}, res, expct);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !outValid && !done, "R1 reset", {125'd0, busy, outValid, done}, 128'd0);
    rstN = 1;
    @(negedge clk);
    check(!busy && !outValid && !done, "R1 after release", {125'd0, busy, outValid, done}, 128'd0);
    // R4: reference model against the known answer
    check(cipherRef(KAT_PT, KAT_KEY) == KAT_CT, "R4 reference", cipherRef(KAT_PT, KAT_KEY), KAT_CT);
    // R5: zero masks
    encrypt(KAT_PT, KAT_KEY, '0, '0, -1, "R5 zero-mask");
    // R6: all-ones masks and random masks
    encrypt(KAT_PT, KAT_KEY, '1, '1, -1, "R6 ones-mask");
    encrypt(KAT_PT, KAT_KEY, rnd128(), rnd128(), -1, "R6 rand-mask");
    // R8: stray start in the middle of the rounds
    encrypt(KAT_PT, KAT_KEY, rnd128(), rnd128(), 1000, "R8 start-ignored");
    // R6 R10: random vectors with random splits
    for (int v = 0; v < 4; v++)
      encrypt(rnd128(), rnd128(), rnd128(), rnd128(), -1, "R6 random");
    // R4: edge patterns
    encrypt('0, '0, rnd128(), rnd128(), -1, "R4 all-zero");
    encrypt('1, '1, rnd128(), rnd128(), -1, "R4 all-one");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule